// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets clocked logic read and write an external asynchronous static RAM of 64K words by 16 bits. Its system side takes one request at a time: an address, a 16-bit write word, two byte-enable bits, a read/write flag and a valid/ready handshake. Read results come back on a data bus with a one-cycle valid strobe. On the memory side it drives active-low chip select, read strobe, write strobe and two byte-lane strobes. The data bus is split into an outgoing word, a drive enable and an incoming word.

All memory timing is counted in clock cycles. The cycle counts come from nanosecond minimums, rounded up to a whole number of clock periods. A read holds the select and read strobes for the access-time count, then registers the enabled lanes. A write first drops the write strobe with the data drivers off, for a turnaround gap. It then drives the word for the data phase. Finally it releases the drivers and all strobes on one edge, so the data setup window is met at the edge that ends the write. The read strobe stays high for the whole write. The block therefore never drives the bus while the memory might be driving it.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1.
- R2: A read accepted with a nonzero req_be holds the following for exactly ACC_CYC cycles:
  - mem_ce_n=0, mem_oe_n=0 and mem_we_n=1.
  - mem_ub_n = ~req_be[1] (bits 15:8) and mem_lb_n = ~req_be[0] (bits 7:0).
  
  In the cycle after those strobes are released, rsp_valid is 1 for one cycle.
- R3: The read result carries mem_dq_in lanes sampled at the last access cycle for the enabled lanes, and zero for lanes whose enable bit was 0.
- R4: A write accepted with a nonzero req_be holds mem_ce_n=0 and mem_we_n=0, with lane strobes as in R2, for exactly TA_CYC + DRV_CYC cycles. Here DRV_CYC = max(SU_CYC, WP_CYC - TA_CYC, 1). mem_oe_n stays 1 throughout.
- R5: mem_dq_oe stays 0 for the first TA_CYC cycles of a write. It is never 1 while mem_oe_n is 0 or mem_we_n is 1.
- R6: mem_dq_oe is 1 for exactly DRV_CYC cycles with mem_dq_out stable and equal to the accepted req_wdata. It falls on the same edge that raises mem_we_n.
- R7: A write changes only the memory lanes whose enable bit was 1; the other lane keeps its previous contents.
- R8: A request with req_be = 0 touches no memory strobe and keeps req_ready at 1. If it is a read, it returns rsp_valid with zero data in the next cycle.
- R9: req_ready is 0 from the accepting edge until the edge that ends the access. A new request may be accepted in the next cycle.
- R10: While mem_ce_n is 0, mem_addr equals the accepted address and the lane strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | word address |
| req_wdata | input | 16 | write word |
| req_be | input | 2 | lane enables: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | read result strobe, one cycle |
| rsp_rdata | output | 16 | read result, disabled lanes zero |
| mem_ce_n | output | 1 | chip select, active low |
| mem_oe_n | output | 1 | read strobe, active low |
| mem_we_n | output | 1 | write strobe, active low |
| mem_ub_n | output | 1 | upper lane strobe, active low |
| mem_lb_n | output | 1 | lower lane strobe, active low |
| mem_addr | output | 16 | memory address |
| mem_dq_out | output | 16 | data driven toward the memory |
| mem_dq_oe | output | 1 | drive enable for mem_dq_out |
| mem_dq_in | input | 16 | data returned by the memory |

## Verification
Take the accepting edge as cycle 0:
- **Read:** the strobes are seen low at the ACC_CYC falling edges that follow. Result, rsp_valid and req_ready are all due at falling edge ACC_CYC+1.
- **Write:** the write strobe is low at TA_CYC+DRV_CYC falling edges. The drive enable is low for the first TA_CYC of them and high for the rest.
- **No-op:** nothing is busy and the result, if any, is due at the first falling edge.

The bench samples only at falling edges. At each one it counts the cycles of every phase until req_ready returns, then compares the counts and data with values it derives from the parameters and a shadow copy of the memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_GAP   = 2'd2,
    ST_DRIVE = 2'd3
  } seq_state_t;

  // whole clock cycles covering a nanosecond minimum, never below one
  function automatic int cyc_ceil(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // data phase length: meets setup, and tops the pulse up past the gap
  function automatic int drive_cycles(input int su, input int wp, input int ta);
    int d;
    d = wp - ta;
    if (d < su) d = su;
    if (d < 1)  d = 1;
    return d;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANES*8-1:0] din,
  output logic               rvalid,
  output logic [LANES*8-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= cap;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata[l*8 +: 8] <= 8'h00;
      else if (cap) rdata[l*8 +: 8] <= lane_en[l] ? din[l*8 +: 8] : 8'h00;
    end

    p_off_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !lane_en[l]) |=> (rdata[l*8 +: 8] == 8'h00));
  end

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> rvalid);
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int ACC_CYC = cyc_ceil(12, CLK_NS),
  parameter int WP_CYC  = cyc_ceil(9, CLK_NS),
  parameter int SU_CYC  = cyc_ceil(6, CLK_NS),
  parameter int TA_CYC  = cyc_ceil(6, CLK_NS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANES*8-1:0] req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               rsp_valid,
  output logic [LANES*8-1:0] rsp_rdata,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic               mem_ub_n,
  output logic               mem_lb_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LANES*8-1:0] mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [LANES*8-1:0] mem_dq_in
);
  localparam int ACC_C = (ACC_CYC < 1) ? 1 : ACC_CYC;
  localparam int TA_C  = (TA_CYC < 1) ? 1 : TA_CYC;
  localparam int DRV_C = drive_cycles(SU_CYC, WP_CYC, TA_C);
  localparam int MAX_C = max3(ACC_C, TA_C, DRV_C);
  localparam int CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_C - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_C - 1);
  localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(DRV_C - 1);

  seq_state_t       state;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  // named events for the checks below
  logic accept, take_rd, take_wr, take_nop, rd_done, gap_done, wr_done;
  logic mem_reads, mem_writes, cap;
  logic [LANES-1:0] cap_en;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign take_nop  = accept && (req_be == '0);
  assign take_rd   = accept && (req_be != '0) && !req_write;
  assign take_wr   = accept && (req_be != '0) && req_write;
  assign rd_done   = (state == ST_READ)  && tmr_done;
  assign gap_done  = (state == ST_GAP)   && tmr_done;
  assign wr_done   = (state == ST_DRIVE) && tmr_done;
  assign mem_reads  = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_writes = !mem_ce_n && !mem_we_n && !(mem_ub_n && mem_lb_n);

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    if (take_rd)       tmr_val = ACC_LD;
    else if (take_wr)  tmr_val = TA_LD;
    else if (gap_done) tmr_val = DRV_LD;
    else               tmr_load = 1'b0;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_rd || take_wr) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            mem_ub_n <= ~req_be[LANES-1];
            mem_lb_n <= ~req_be[0];
          end
          if (take_rd) begin
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end
          if (take_wr) begin
            mem_we_n   <= 1'b0;
            mem_dq_out <= req_wdata;
            state      <= ST_GAP;
          end
        end
        ST_READ: if (rd_done) begin
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_GAP: if (gap_done) begin
          mem_dq_oe <= 1'b1;
          state     <= ST_DRIVE;
        end
        ST_DRIVE: if (wr_done) begin
          mem_ce_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cap    = rd_done || (take_nop && !req_write);
  assign cap_en = rd_done ? ~{mem_ub_n, mem_lb_n} : '0;

  sram_lane_capture #(.LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .lane_en(cap_en),
    .din(mem_dq_in), .rvalid(rsp_valid), .rdata(rsp_rdata)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_no_fight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_reads && mem_writes));
  p_gap_before_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_we_n && mem_oe_n));
  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  p_release_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_we_n && mem_ce_n));
  p_lane_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_ub_n && mem_lb_n));
  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));
endmodule

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;
  localparam int ACC = 3, WP = 3, SU = 1, TA = 1;
  localparam int DRV = ((WP - TA) > SU) ? (WP - TA) : SU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [15:0] rsp_rdata, m_addr, dq_out, dq_in;

  int tests = 0, fails = 0;
  logic [15:0] mem_q [256];
  logic [15:0] shadow [256];

  always #5 clk = ~clk;

  sram_port_ctrl #(.CLK_NS(10), .ACC_CYC(ACC), .WP_CYC(WP), .SU_CYC(SU), .TA_CYC(TA)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(ce_n), .mem_oe_n(oe_n),
    .mem_we_n(we_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n), .mem_addr(m_addr),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in));

  // memory model: enabled lanes drive on read, floating lanes show junk
  wire rd_drv = !ce_n && !oe_n && we_n;
  always_comb begin
    dq_in[15:8] = (rd_drv && !ub_n) ? mem_q[m_addr[7:0]][15:8] : 8'hEE;
    dq_in[7:0]  = (rd_drv && !lb_n) ? mem_q[m_addr[7:0]][7:0]  : 8'hEE;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !we_n && dq_oe) begin
      if (!ub_n) mem_q[m_addr[7:0]][15:8] <= dq_out[15:8];
      if (!lb_n) mem_q[m_addr[7:0]][7:0]  <= dq_out[7:0];
    end
    if (dq_oe && rd_drv) begin
      fails++;
      $display("FAIL R5 bus fight actual=1 expected=0");
    end
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    int nwe = 0, ngap = 0, ndrv = 0, nbusy = 0, nbad = 0;
    int exp_we = (be != 0) ? TA + DRV : 0;
    issue(1'b1, {8'h00, a}, d, be);
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (req_ready) break;
      nbusy++;
      if (!we_n) nwe++;
      if (!we_n && !dq_oe) ngap++;
      if (dq_oe) begin
        ndrv++;
        if (dq_out !== d) nbad++;
      end
      if (!oe_n) nbad++;
      if (m_addr[7:0] !== a || ub_n !== ~be[1] || lb_n !== ~be[0]) nbad++;
    end
    chk(nwe == exp_we, "R4 write strobe cycles", nwe, exp_we);
    chk(ngap == ((be != 0) ? TA : 0), "R5 turnaround gap", ngap, (be != 0) ? TA : 0);
    chk(ndrv == ((be != 0) ? DRV : 0), "R6 drive cycles", ndrv, (be != 0) ? DRV : 0);
    chk(nbusy == exp_we, "R9 busy window", nbusy, exp_we);
    chk(nbad == 0, "R10 addr/strobe/data held, oe high", nbad, 0);
    chk(we_n && !dq_oe, "R6 release together", {we_n, dq_oe}, 2'b10);
    if (be[1]) shadow[a][15:8] = d[15:8];
    if (be[0]) shadow[a][7:0]  = d[7:0];
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] be);
    int nacc = 0, nbad = 0;
    int exp_acc = (be != 0) ? ACC : 0;
    logic [15:0] exp;
    exp = shadow[a] & {{8{be[1]}}, {8{be[0]}}};
    issue(1'b0, {8'h00, a}, 16'h0, be);
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (req_ready) break;
      if (!rd_drv) nbad++;
      if (m_addr[7:0] !== a || ub_n !== ~be[1] || lb_n !== ~be[0]) nbad++;
      if (rsp_valid) nbad++;
      nacc++;
    end
    if (be == 0) chk(nacc == 0 && ce_n, "R8 no-op read", nacc, 0);
    else         chk(nacc == exp_acc, "R2 access cycles", nacc, exp_acc);
    chk(nbad == 0, "R10 read strobes held", nbad, 0);
    chk(rsp_valid === 1'b1, "R2 response due", rsp_valid, 1);
    chk(rsp_rdata === exp, (be == 2'b11) ? "R7 lane write readback" : "R3 lane masking", rsp_rdata, exp);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 one-cycle response", rsp_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_q[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !dq_oe && ce_n && oe_n && we_n && ub_n && lb_n,
        "R1 reset state", {req_ready, rsp_valid, dq_oe, ce_n, oe_n, we_n, ub_n, lb_n}, 8'h9F);
    rst_n = 1'b1;
    // R7: write full words, then overwrite one lane at a time
    for (int a = 0; a < 32; a++)
      do_write(a[7:0], {a[7:0] ^ 8'h5A, ~a[7:0]}, 2'b11);
    for (int a = 0; a < 32; a++)
      for (int be = 0; be < 4; be++)
        do_write(a[7:0], {a[7:0] + 8'h31 * be[7:0], 8'hC3 ^ a[7:0] ^ be[7:0]}, be[1:0]);
    // R8: no-op write must leave the word untouched
    do_write(8'd7, 16'hFFFF, 2'b00);
    for (int a = 0; a < 32; a++)
      for (int be = 0; be < 4; be++)
        do_read(a[7:0], be[1:0]);
    chk(mem_q[7] === shadow[7], "R8 no-op write ignored", mem_q[7], shadow[7]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule